// File: doc/BRIEF.md
# Alarm Match and Interrupt Controller

This block sits beside a once-per-second timekeeping counter. At the strobe that marks the end of each one-second advance, it checks the freshly updated hours, minutes and seconds fields against three alarm bytes. An alarm byte whose two top bits are both 1 is a wildcard and matches any time value. Wildcards therefore let the alarm fire once a day, once an hour, once a minute or once a second.

Three event sources feed a small status register: the alarm match, a periodic tick and an end-of-update strobe. Each source sets its own sticky flag whether or not it is enabled, so software can poll the flags. Each source also has its own enable. A summary bit in the status byte is high while any flag is set together with its enable. The same condition drives an active-low interrupt request, which is modelled as an output enable with a constant low data value, as an open-drain pin would be. A read strobe on the status register clears all three flags and so releases the request.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After synchronous reset, `stat_data_o` is 0x00 and `irq_oe_o` is 0.
- R2: When `tick_i` is high and each alarm byte equals its time field, status bit 5 (alarm flag) reads 1 from the clock edge that samples the tick.
- R3: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its time field. With only the hours byte wildcarded, an equal minutes and seconds pair still raises the alarm flag.
- R4: A match without `tick_i` does not set the alarm flag.
- R5: `periodic_evt_i` sets status bit 6, and `update_evt_i` sets status bit 4, from the next clock edge.
- R6: Flags set whatever the enable inputs are, and they stay set until a status read.
- R7: Status bit 7 and `irq_oe_o` are high exactly while some flag is set with its enable high (periodic with `en_periodic_i`, alarm with `en_alarm_i`, update with `en_update_i`). `irq_data_o` is always 0.
- R8: A clock edge that samples `stat_rd_i` high clears every flag that has no new event in that cycle.
- R9: An event in the same cycle as `stat_rd_i` leaves its flag set after that edge.
- R10: Status bits 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe: the time fields have just advanced |
| time_hr_i | input | 8 | Current hours byte |
| time_min_i | input | 8 | Current minutes byte |
| time_sec_i | input | 8 | Current seconds byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_sec_i | input | 8 | Seconds alarm byte |
| periodic_evt_i | input | 1 | Periodic event strobe |
| update_evt_i | input | 1 | End-of-update event strobe |
| en_periodic_i | input | 1 | Periodic interrupt enable |
| en_alarm_i | input | 1 | Alarm interrupt enable |
| en_update_i | input | 1 | Update-ended interrupt enable |
| stat_rd_i | input | 1 | Status read strobe; clears the flags at the edge |
| stat_data_o | output | 8 | Status byte: 7 summary, 6 periodic, 5 alarm, 4 update, 3:0 zero |
| irq_oe_o | output | 1 | Interrupt pin drive enable |
| irq_data_o | output | 1 | Interrupt pin data value, constant 0 |

## Verification
The clearing read and a new event can fall in the same cycle. A status read that clears every flag may coincide with a periodic strobe, an update strobe or a matching tick. The bench provokes this on purpose in directed cycles, and the random stream does so often. A reference model computes the flag state after each edge with set taking priority over clear. The status byte and the interrupt enable are compared against that model one time unit after the edge.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 3;
    localparam int N_SRC    = 3;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t hr;
        field_t mn;
        field_t sc;
    } hms_t;

    typedef struct packed {
        logic periodic;
        logic alarm;
        logic update;
    } src_vec_t;

    // Wildcard: both top bits set
    function automatic logic is_wildcard(input field_t b);
        return b[FIELD_W-1] & b[FIELD_W-2];
    endfunction

    function automatic logic field_hits(input field_t alm, input field_t now);
        return is_wildcard(alm) || (alm == now);
    endfunction

    function automatic field_t pick_field(input hms_t v, input int idx);
        case (idx)
            0:       return v.sc;
            1:       return v.mn;
            default: return v.hr;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(input logic summary, input src_vec_t f);
        return {summary, f.periodic, f.alarm, f.update, 4'b0000};
    endfunction

endpackage

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_irq_pkg::*;
(
    input  hms_t now_i,
    input  hms_t alm_i,
    input  logic tick_i,
    output logic hit_o
);
    logic [N_FIELDS-1:0] field_ok;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        assign field_ok[g] = field_hits(pick_field(alm_i, g), pick_field(now_i, g));
    end

    assign hit_o = tick_i & (&field_ok);
endmodule

// File: rtl/status_flags.sv
module status_flags
    import alarm_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  logic     clr_i,
    output src_vec_t flags_o
);
    logic [N_SRC-1:0] set_v;
    logic [N_SRC-1:0] q;

    assign set_v = set_i;

    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= 1'b0;
            else if (set_v[g])
                q[g] <= 1'b1;
            else if (clr_i)
                q[g] <= 1'b0;
        end
    end

    assign flags_o = q;
endmodule

// File: rtl/irq_driver.sv
module irq_driver
    import alarm_irq_pkg::*;
(
    input  src_vec_t flags_i,
    input  src_vec_t en_i,
    output logic     summary_o,
    output logic     oe_o,
    output logic     data_o
);
    assign summary_o = |(flags_i & en_i);
    assign oe_o      = summary_o;
    assign data_o    = 1'b0;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int BYTE_W = FIELD_W,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [BYTE_W-1:0] time_hr_i,
    input  logic [BYTE_W-1:0] time_min_i,
    input  logic [BYTE_W-1:0] time_sec_i,
    input  logic [BYTE_W-1:0] alm_hr_i,
    input  logic [BYTE_W-1:0] alm_min_i,
    input  logic [BYTE_W-1:0] alm_sec_i,
    input  logic              periodic_evt_i,
    input  logic              update_evt_i,
    input  logic              en_periodic_i,
    input  logic              en_alarm_i,
    input  logic              en_update_i,
    input  logic              stat_rd_i,
    output logic [STAT_W-1:0] stat_data_o,
    output logic              irq_oe_o,
    output logic              irq_data_o
);
    hms_t     now_s, alm_s;
    logic     alarm_hit;
    src_vec_t set_s, en_s, flags_s;
    logic     summary;

    assign now_s = '{hr: time_hr_i, mn: time_min_i, sc: time_sec_i};
    assign alm_s = '{hr: alm_hr_i,  mn: alm_min_i,  sc: alm_sec_i};

    alarm_compare u_cmp (
        .now_i  (now_s),
        .alm_i  (alm_s),
        .tick_i (tick_i),
        .hit_o  (alarm_hit)
    );

    assign set_s = '{periodic: periodic_evt_i, alarm: alarm_hit, update: update_evt_i};
    assign en_s  = '{periodic: en_periodic_i,  alarm: en_alarm_i, update: en_update_i};

    status_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_s),
        .clr_i   (stat_rd_i),
        .flags_o (flags_s)
    );

    irq_driver u_irq (
        .flags_i   (flags_s),
        .en_i      (en_s),
        .summary_o (summary),
        .oe_o      (irq_oe_o),
        .data_o    (irq_data_o)
    );

    assign stat_data_o = pack_status(summary, flags_s);
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       periodic_evt_i,
    input logic       update_evt_i,
    input logic       stat_rd_i,
    input logic [7:0] stat_data_o,
    input logic       irq_oe_o,
    input logic       irq_data_o
);
    assert_irq_tracks_summary_R7: assert property (@(posedge clk) disable iff (rst)
        irq_oe_o == stat_data_o[7]);

    assert_irq_data_low_R7: assert property (@(posedge clk) disable iff (rst)
        irq_data_o == 1'b0);

    assert_low_nibble_zero_R10: assert property (@(posedge clk) disable iff (rst)
        stat_data_o[3:0] == 4'h0);

    assert_alarm_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_data_o[5]) |-> $past(tick_i));

    assert_periodic_sets_R5: assert property (@(posedge clk) disable iff (rst)
        periodic_evt_i |=> stat_data_o[6]);

    assert_update_sets_R5: assert property (@(posedge clk) disable iff (rst)
        update_evt_i |=> stat_data_o[4]);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_data_o[6] && !stat_rd_i) |=> stat_data_o[6]);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && !tick_i && !periodic_evt_i && !update_evt_i) |=> (stat_data_o[6:4] == 3'b000));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && update_evt_i) |=> stat_data_o[4]);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick_i),
    .periodic_evt_i (periodic_evt_i),
    .update_evt_i   (update_evt_i),
    .stat_rd_i      (stat_rd_i),
    .stat_data_o    (stat_data_o),
    .irq_oe_o       (irq_oe_o),
    .irq_data_o     (irq_data_o)
);

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
    logic       clk = 0;
    logic       rst;
    logic       tick_i;
    logic [7:0] time_hr_i, time_min_i, time_sec_i;
    logic [7:0] alm_hr_i, alm_min_i, alm_sec_i;
    logic       periodic_evt_i, update_evt_i;
    logic       en_periodic_i, en_alarm_i, en_update_i;
    logic       stat_rd_i;
    logic [7:0] stat_data_o;
    logic       irq_oe_o, irq_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic ep = 0, ea = 0, eu = 0;   // model flags

    always #5 clk = ~clk;

    alarm_irq_ctrl dut (.*);

    function automatic logic fmatch(input logic [7:0] a, input logic [7:0] t);
        return (a[7:6] == 2'b11) || (a == t);
    endfunction

    function automatic logic [7:0] exp_stat();
        logic s;
        s = (ep & en_periodic_i) | (ea & en_alarm_i) | (eu & en_update_i);
        return {s, ep, ea, eu, 4'b0000};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic drive(input logic tk, input logic [7:0] th, tm, ts, ah, am, as_,
                         input logic pe, ue, enp, ena, enu, rd, input string req);
        logic hit;
        @(negedge clk);
        tick_i = tk; time_hr_i = th; time_min_i = tm; time_sec_i = ts;
        alm_hr_i = ah; alm_min_i = am; alm_sec_i = as_;
        periodic_evt_i = pe; update_evt_i = ue;
        en_periodic_i = enp; en_alarm_i = ena; en_update_i = enu; stat_rd_i = rd;
        hit = tk & fmatch(ah, th) & fmatch(am, tm) & fmatch(as_, ts);
        @(posedge clk);
        ep = pe  | (ep & ~rd);
        ea = hit | (ea & ~rd);
        eu = ue  | (eu & ~rd);
        #1;
        check(req, stat_data_o, exp_stat());
        check("R7", {7'b0, irq_oe_o}, {7'b0, exp_stat()}[7] ? 8'h01 : 8'h00);
        check("R7", {7'b0, irq_data_o}, 8'h00);
        check("R10", {4'h0, stat_data_o[3:0]}, 8'h00);
    endtask

    // Clear with a read, all inputs quiet
    task automatic quiet_read();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, "R8");
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        tick_i = 0; time_hr_i = 0; time_min_i = 0; time_sec_i = 0;
        alm_hr_i = 0; alm_min_i = 0; alm_sec_i = 0;
        periodic_evt_i = 0; update_evt_i = 0;
        en_periodic_i = 1; en_alarm_i = 1; en_update_i = 1; stat_rd_i = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", stat_data_o, 8'h00);
        check("R1", {7'b0, irq_oe_o}, 8'h00);
        @(negedge clk); rst = 0;

        // R2 exact match at tick
        drive(1, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56, 0, 0, 1, 1, 1, 0, "R2");
        check("R2", {7'b0, stat_data_o[5]}, 8'h01);
        quiet_read();
        // R4 match but no tick
        drive(0, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56, 0, 0, 1, 1, 1, 0, "R4");
        check("R4", {7'b0, stat_data_o[5]}, 8'h00);
        // R3 hourly: hours wildcard, hour differs
        drive(1, 8'h07, 8'h00, 8'h00, 8'hC0, 8'h00, 8'h00, 0, 0, 1, 1, 1, 0, "R3");
        check("R3", {7'b0, stat_data_o[5]}, 8'h01);
        quiet_read();
        // R3 every second: all wildcards
        drive(1, 8'h23, 8'h59, 8'h41, 8'hFF, 8'hD5, 8'hC3, 0, 0, 1, 1, 1, 0, "R3");
        // R3 mismatch on seconds with hours/minutes wildcard
        quiet_read();
        drive(1, 8'h23, 8'h59, 8'h41, 8'hFF, 8'hFF, 8'h40, 0, 0, 1, 1, 1, 0, "R3");
        check("R3", {7'b0, stat_data_o[5]}, 8'h00);
        // R6 flags set with enables off, irq stays released
        drive(1, 8'h01, 8'h02, 8'h03, 8'h01, 8'h02, 8'h03, 1, 1, 0, 0, 0, 0, "R6");
        check("R6", stat_data_o, 8'h70);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        check("R6", stat_data_o, 8'h70);
        // R7 enable one source
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
        check("R7", {7'b0, irq_oe_o}, 8'h01);
        // R9 read coincides with events
        drive(1, 8'h05, 8'h05, 8'h05, 8'hC0, 8'hC0, 8'h05, 1, 1, 1, 1, 1, 1, "R9");
        check("R9", stat_data_o, 8'hF0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, "R9");
        check("R9", stat_data_o, 8'h90);
        quiet_read();
        check("R8", stat_data_o, 8'h00);
        // R5 single sources
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 1, 0, "R5");
        check("R5", stat_data_o, 8'hC0);
        quiet_read();

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] th, tm, ts, ah, am, as_;
            logic tk, pe, ue, rd;
            string tag;
            th = 8'($urandom_range(0, 35)); tm = 8'($urandom_range(0, 59)); ts = 8'($urandom_range(0, 59));
            ah = ($urandom_range(0, 2) == 0) ? th : (($urandom_range(0, 1) == 0) ? 8'hC0 | 8'($urandom_range(0, 63)) : 8'($urandom_range(0, 59)));
            am = ($urandom_range(0, 2) != 0) ? tm : 8'hC0 | 8'($urandom_range(0, 63));
            as_ = ($urandom_range(0, 2) != 0) ? ts : 8'($urandom_range(0, 255));
            tk = ($urandom_range(0, 2) == 0);
            pe = ($urandom_range(0, 3) == 0);
            ue = ($urandom_range(0, 3) == 0);
            rd = ($urandom_range(0, 3) == 0);
            if (rd && (pe || ue || tk)) tag = "R9";
            else if (rd)                tag = "R8";
            else if (tk)                tag = "R2";
            else if (pe || ue)          tag = "R5";
            else                        tag = "R6";
            drive(tk, th, tm, ts, ah, am, as_, pe, ue,
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rd, tag);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule